// File: doc/BRIEF.md
# Hamsi-512 Round Permutation Core

This block performs the internal permutation of a 512-bit-output wide-pipe hash of the Hamsi family. It works on a 32-word state of 32-bit words. A caller presents sixteen expanded message words, the sixteen current chaining words and a mode bit, then pulses `start`. The core interleaves message and chaining words into the working state and runs one full round per clock. When the last round is done it returns the new chaining value, which is the old chaining value XORed with half of the permuted state.

Each round has three steps. It adds a 32-entry constant table to the state, one entry per word, and XORs the round number into word 1. It then applies a four-input bitsliced substitution to each of the eight columns. Finally it runs a rotate/shift/XOR mixer over eight diagonal groups and then over four further groups.

Mode bit 0 selects the ordinary compression permutation: six rounds with the first constant table. Mode bit 1 selects the closing permutation: twelve rounds with the second table. Message expansion, padding and byte ordering belong to the caller.

Top module: `spn512_perm_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `chain_out` is all zero.
- R2: While `busy` is 0, a `start` pulse is accepted. `busy` is 1 in the cycle after the accepting edge and stays 1 until the last round has been applied.
- R3: With `final_mode`=0 at the accepting edge, exactly 6 rounds run with counter values 0..5. With `final_mode`=1, exactly 12 rounds run with counter values 0..11, and `done` rises 12 clocks after the accepting edge instead of 6.
- R4: `done` is a single-cycle pulse. `busy` is 0 while `done` is 1, so a new `start` may be accepted in that same cycle.
- R5: `start` and all data inputs are ignored while `busy` is 1. Changing them mid-run leaves the result unchanged.
- R6: The state is loaded as follows, with word k at bits [32k+31:32k] of each bus. State words 0,1,4,5,10,11,14,15,16,17,20,21,26,27,30,31 take message words 0..15 in that order. State words 2,3,6,7,8,9,12,13,18,19,22,23,24,25,28,29 take chaining words 0..15 in that order.
- R7: Each round XORs word i of the selected constant table into state word i for all 32 words. It also XORs the zero-extended round counter into state word 1.
- R8: The substitution acts on the column (s[i], s[i+8], s[i+16], s[i+24]) for i=0..7, using the fixed AND/OR/XOR/NOT network. That network ends by permuting its four words and complementing the last one.
- R9: The mixer on (a,b,c,d) works in this order:
  - a is rotated left by 13 and c left by 3.
  - b gets a^c, and d gets c^(a<<3).
  - b is rotated left by 1 and d left by 7.
  - a gets b^d, and c gets d^(b<<7).
  - a is rotated left by 5 and c left by 22.

  It is applied to groups (x, 8+(x+1)%8, 16+(x+2)%8, 24+(x+3)%8) for x=0..7, then to (0,2,5,7), (16,19,21,22), (9,11,12,14) and (25,26,28,31).
- R10: The result word i is chaining word i XOR final state word i for i<8, and chaining word i XOR final state word i+8 for i=8..15.
- R11: `chain_out` changes only at the edge that raises `done`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a permutation when idle |
| final_mode | input | 1 | 0: 6-round permutation, 1: 12-round closing permutation |
| msg_in | input | 512 | Sixteen expanded message words, word k at [32k+31:32k] |
| chain_in | input | 512 | Sixteen chaining words, word k at [32k+31:32k] |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when `chain_out` is updated |
| chain_out | output | 512 | Updated chaining value, registered |

## Verification
The bench builds the core with its default round counts of 6 and 12. Those values bring both constant tables into play, along with the full counter range that reaches word 1. They also cover the difference between the two latencies. Every clock, a behavioural model written with integer arrays and explicit group tables predicts `busy`, `done` and `chain_out`. The stimulus covers all-zero and all-one words, walking and random patterns in both modes, a `start` with altered data in the middle of a run, and a restart in the very cycle `done` is high.

// File: rtl/spn512_pkg.sv
`timescale 1ns/1ps
package spn512_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 32;
  localparam int CHAIN_WORDS = 16;
  localparam int COLS        = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STATE_WORDS-1:0][WORD_W-1:0] state_t;
  typedef logic [CHAIN_WORDS-1:0][WORD_W-1:0] chain_t;
  typedef logic [3:0][WORD_W-1:0] quad_t;  // [0]=a [1]=b [2]=c [3]=d

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // bitsliced 4-input substitution on one column
  function automatic quad_t sbox4(input quad_t q);
    word_t a, b, c, d, t;
    quad_t r;
    a = q[0]; b = q[1]; c = q[2]; d = q[3];
    t = a;
    a = d ^ (a & c);
    c = a ^ c ^ b;
    d = b ^ (d | t);
    t = t ^ c;
    b = d;
    d = a ^ (d | t);
    a = a & b;
    t = t ^ a;
    b = t ^ b ^ d;
    r[0] = c;
    r[1] = d;
    r[2] = b;
    r[3] = ~t;
    return r;
  endfunction

  // rotate/shift diffusion on four words
  function automatic quad_t lmix(input quad_t q);
    word_t a, b, c, d;
    quad_t r;
    a = rotl(q[0], 13);
    c = rotl(q[2], 3);
    b = q[1] ^ a ^ c;
    d = q[3] ^ c ^ (a << 3);
    b = rotl(b, 1);
    d = rotl(d, 7);
    a = a ^ b ^ d;
    c = c ^ d ^ (b << 7);
    r[0] = rotl(a, 5);
    r[1] = b;
    r[2] = rotl(c, 22);
    r[3] = d;
    return r;
  endfunction

  // two round-constant tables, indexed by word position
  function automatic word_t round_const(input logic fin, input logic [4:0] idx);
    word_t w;
    case (idx)
      5'd0:  w = fin ? 32'hcaf9639c : 32'hff00f0f0;
      5'd1:  w = fin ? 32'h0ff0f9c0 : 32'hccccaaaa;
      5'd2:  w = fin ? 32'h639c0ff0 : 32'hf0f0cccc;
      5'd3:  w = fin ? 32'hcaf9f9c0 : 32'hff00aaaa;
      5'd4:  w = fin ? 32'h0ff0f9c0 : 32'hccccaaaa;
      5'd5:  w = fin ? 32'h639ccaf9 : 32'hf0f0ff00;
      5'd6:  w = fin ? 32'hf9c00ff0 : 32'haaaacccc;
      5'd7:  w = fin ? 32'h639ccaf9 : 32'hf0f0ff00;
      5'd8:  w = fin ? 32'h639c0ff0 : 32'hf0f0cccc;
      5'd9:  w = fin ? 32'hf9c0caf9 : 32'haaaaff00;
      5'd10: w = fin ? 32'h0ff0caf9 : 32'hccccff00;
      5'd11: w = fin ? 32'hf9c0639c : 32'haaaaf0f0;
      5'd12: w = fin ? 32'hf9c0639c : 32'haaaaf0f0;
      5'd13: w = fin ? 32'hcaf90ff0 : 32'hff00cccc;
      5'd14: w = fin ? 32'h0ff0639c : 32'hccccf0f0;
      5'd15: w = fin ? 32'hcaf9f9c0 : 32'hff00aaaa;
      5'd16: w = fin ? 32'h0ff0f9c0 : 32'hccccaaaa;
      5'd17: w = fin ? 32'hcaf9639c : 32'hff00f0f0;
      5'd18: w = fin ? 32'hcaf9f9c0 : 32'hff00aaaa;
      5'd19: w = fin ? 32'h639c0ff0 : 32'hf0f0cccc;
      5'd20: w = fin ? 32'h639ccaf9 : 32'hf0f0ff00;
      5'd21: w = fin ? 32'h0ff0f9c0 : 32'hccccaaaa;
      5'd22: w = fin ? 32'h639ccaf9 : 32'hf0f0ff00;
      5'd23: w = fin ? 32'hf9c00ff0 : 32'haaaacccc;
      5'd24: w = fin ? 32'hf9c0caf9 : 32'haaaaff00;
      5'd25: w = fin ? 32'h639c0ff0 : 32'hf0f0cccc;
      5'd26: w = fin ? 32'hf9c0639c : 32'haaaaf0f0;
      5'd27: w = fin ? 32'h0ff0caf9 : 32'hccccff00;
      5'd28: w = fin ? 32'hcaf90ff0 : 32'hff00cccc;
      5'd29: w = fin ? 32'hf9c0639c : 32'haaaaf0f0;
      5'd30: w = fin ? 32'hcaf9f9c0 : 32'hff00aaaa;
      default: w = fin ? 32'h0ff0639c : 32'hccccf0f0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/spn512_const_rom.sv
`timescale 1ns/1ps
module spn512_const_rom
  import spn512_pkg::*;
(
  input  logic   fin,
  output state_t cst
);
  for (genvar i = 0; i < STATE_WORDS; i++) begin : g_word
    assign cst[i] = round_const(fin, 5'(i));
  end
endmodule

// File: rtl/spn512_loader.sv
`timescale 1ns/1ps
module spn512_loader
  import spn512_pkg::*;
(
  input  chain_t msg,
  input  chain_t chain,
  output state_t st
);
  // within each 16-word half, position p holds a message word when
  // bit 1 and bit 3 of p agree; both sources share the same rank formula
  for (genvar p = 0; p < STATE_WORDS; p++) begin : g_pos
    localparam int Q   = p % 16;
    localparam int SRC = (p / 16) * 8 + 2 * (Q / 4) + (Q % 2);
    if (((Q >> 1) & 1) == ((Q >> 3) & 1)) begin : g_msg
      assign st[p] = msg[SRC];
    end else begin : g_chn
      assign st[p] = chain[SRC];
    end
  end
endmodule

// File: rtl/spn512_round.sv
`timescale 1ns/1ps
module spn512_round
  import spn512_pkg::*;
(
  input  state_t st_in,
  input  word_t  rnd,
  input  state_t cst,
  output state_t st_out
);
  localparam int GRP2 [4][4] = '{'{0, 2, 5, 7}, '{16, 19, 21, 22},
                                 '{9, 11, 12, 14}, '{25, 26, 28, 31}};

  state_t ka, sb, l1;

  // constant addition; counter enters word 1 only
  always_comb begin
    ka = st_in ^ cst;
    ka[1] = ka[1] ^ rnd;
  end

  // substitution on the eight columns
  for (genvar i = 0; i < COLS; i++) begin : g_col
    quad_t qi, qo;
    assign qi = {ka[i+24], ka[i+16], ka[i+8], ka[i]};
    assign qo = sbox4(qi);
    assign sb[i]    = qo[0];
    assign sb[i+8]  = qo[1];
    assign sb[i+16] = qo[2];
    assign sb[i+24] = qo[3];
  end

  // mixer over diagonal groups, each word touched once
  for (genvar x = 0; x < COLS; x++) begin : g_diag
    localparam int I1 = 8  + ((x + 1) % 8);
    localparam int I2 = 16 + ((x + 2) % 8);
    localparam int I3 = 24 + ((x + 3) % 8);
    quad_t di, dq;
    assign di = {sb[I3], sb[I2], sb[I1], sb[x]};
    assign dq = lmix(di);
    assign l1[x]  = dq[0];
    assign l1[I1] = dq[1];
    assign l1[I2] = dq[2];
    assign l1[I3] = dq[3];
  end

  // second mixer pass over four fixed groups
  always_comb begin
    quad_t q;
    st_out = l1;
    for (int g = 0; g < 4; g++) begin
      q = {l1[GRP2[g][3]], l1[GRP2[g][2]], l1[GRP2[g][1]], l1[GRP2[g][0]]};
      q = lmix(q);
      st_out[GRP2[g][0]] = q[0];
      st_out[GRP2[g][1]] = q[1];
      st_out[GRP2[g][2]] = q[2];
      st_out[GRP2[g][3]] = q[3];
    end
  end
endmodule

// File: rtl/spn512_perm_core.sv
`timescale 1ns/1ps
module spn512_perm_core
  import spn512_pkg::*;
#(
  parameter int NORMAL_ROUNDS = 6,
  parameter int FINAL_ROUNDS  = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         final_mode,
  input  logic [511:0] msg_in,
  input  logic [511:0] chain_in,
  output logic         busy,
  output logic         done,
  output logic [511:0] chain_out
);
  localparam int MAX_R = (FINAL_ROUNDS > NORMAL_ROUNDS) ? FINAL_ROUNDS : NORMAL_ROUNDS;
  localparam int RW    = $clog2(MAX_R + 1);

  chain_t msg_w, chn_w, ff, h_q, out_q;
  state_t loaded, st_q, st_next, cst;
  logic [RW-1:0] rnd_q, last_rnd;
  logic busy_q, done_q, fin_q;
  word_t rnd_w;

  assign msg_w    = msg_in;
  assign chn_w    = chain_in;
  assign last_rnd = fin_q ? RW'(FINAL_ROUNDS - 1) : RW'(NORMAL_ROUNDS - 1);
  assign rnd_w    = word_t'(rnd_q);

  spn512_loader u_load (.msg(msg_w), .chain(chn_w), .st(loaded));
  spn512_const_rom u_rom (.fin(fin_q), .cst(cst));
  spn512_round u_round (.st_in(st_q), .rnd(rnd_w), .cst(cst), .st_out(st_next));

  // feed-forward: low half of each state half into the chaining value
  for (genvar i = 0; i < CHAIN_WORDS; i++) begin : g_ff
    localparam int SI = (i < 8) ? i : i + 8;
    assign ff[i] = h_q[i] ^ st_next[SI];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fin_q  <= 1'b0;
      rnd_q  <= '0;
      st_q   <= '0;
      h_q    <= '0;
      out_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          st_q   <= loaded;
          h_q    <= chn_w;
          fin_q  <= final_mode;
          rnd_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        st_q  <= st_next;
        rnd_q <= rnd_q + 1'b1;
        if (rnd_q == last_rnd) begin
          rnd_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          out_q  <= ff;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign chain_out = out_q;

  // independent run-length counter used only by the checks below
  logic [RW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)                  lat_q <= '0;
    else if (!busy_q && start) lat_q <= '0;
    else if (busy_q)          lat_q <= lat_q + 1'b1;
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rnd_q <= last_rnd));
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == (fin_q ? RW'(FINAL_ROUNDS) : RW'(NORMAL_ROUNDS))));
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(chain_out));
endmodule

// File: tb/spn512_perm_core_tb_top.sv
`timescale 1ns/1ps
module spn512_perm_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic final_mode = 1'b0;
  logic [511:0] msg_in = '0, chain_in = '0;
  logic busy, done;
  logic [511:0] chain_out;

  always #4 clk = ~clk;  // 125 MHz

  spn512_perm_core dut_i (
    .clk(clk), .rst(rst), .start(start), .final_mode(final_mode),
    .msg_in(msg_in), .chain_in(chain_in),
    .busy(busy), .done(done), .chain_out(chain_out));

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  localparam logic [31:0] CN [32] = '{
    32'hff00f0f0, 32'hccccaaaa, 32'hf0f0cccc, 32'hff00aaaa, 32'hccccaaaa, 32'hf0f0ff00,
    32'haaaacccc, 32'hf0f0ff00, 32'hf0f0cccc, 32'haaaaff00, 32'hccccff00, 32'haaaaf0f0,
    32'haaaaf0f0, 32'hff00cccc, 32'hccccf0f0, 32'hff00aaaa, 32'hccccaaaa, 32'hff00f0f0,
    32'hff00aaaa, 32'hf0f0cccc, 32'hf0f0ff00, 32'hccccaaaa, 32'hf0f0ff00, 32'haaaacccc,
    32'haaaaff00, 32'hf0f0cccc, 32'haaaaf0f0, 32'hccccff00, 32'hff00cccc, 32'haaaaf0f0,
    32'hff00aaaa, 32'hccccf0f0};
  localparam logic [31:0] CF [32] = '{
    32'hcaf9639c, 32'h0ff0f9c0, 32'h639c0ff0, 32'hcaf9f9c0, 32'h0ff0f9c0, 32'h639ccaf9,
    32'hf9c00ff0, 32'h639ccaf9, 32'h639c0ff0, 32'hf9c0caf9, 32'h0ff0caf9, 32'hf9c0639c,
    32'hf9c0639c, 32'hcaf90ff0, 32'h0ff0639c, 32'hcaf9f9c0, 32'h0ff0f9c0, 32'hcaf9639c,
    32'hcaf9f9c0, 32'h639c0ff0, 32'h639ccaf9, 32'h0ff0f9c0, 32'h639ccaf9, 32'hf9c00ff0,
    32'hf9c0caf9, 32'h639c0ff0, 32'hf9c0639c, 32'h0ff0caf9, 32'hcaf90ff0, 32'hf9c0639c,
    32'hcaf9f9c0, 32'h0ff0639c};
  localparam int MPOS [16] = '{0,1,4,5,10,11,14,15,16,17,20,21,26,27,30,31};
  localparam int CPOS [16] = '{2,3,6,7,8,9,12,13,18,19,22,23,24,25,28,29};
  localparam int LG [12][4] = '{
    '{0,9,18,27}, '{1,10,19,28}, '{2,11,20,29}, '{3,12,21,30},
    '{4,13,22,31}, '{5,14,23,24}, '{6,15,16,25}, '{7,8,17,26},
    '{0,2,5,7}, '{16,19,21,22}, '{9,11,12,14}, '{25,26,28,31}};

  // behavioural model state
  int unsigned ms [32];
  int unsigned mh [16];
  int unsigned mo [16];
  bit mbusy = 0, mdone = 0, mfin = 0;
  int mcnt = 0, mlim = 6;

  function automatic int unsigned rl(int unsigned x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic m_sbox(int i0, int i1, int i2, int i3);
    int unsigned a = ms[i0], b = ms[i1], c = ms[i2], d = ms[i3], t;
    t = a; a = d ^ (a & c); c = a ^ c ^ b; d = b ^ (d | t); t = t ^ c;
    b = d; d = a ^ (d | t); a = a & b; t = t ^ a; b = t ^ b ^ d;
    ms[i0] = c; ms[i1] = d; ms[i2] = b; ms[i3] = ~t;
  endtask

  task automatic m_mix(int i0, int i1, int i2, int i3);
    int unsigned a = ms[i0], b = ms[i1], c = ms[i2], d = ms[i3];
    a = rl(a, 13); c = rl(c, 3);
    b = b ^ a ^ c; d = d ^ c ^ (a << 3);
    b = rl(b, 1); d = rl(d, 7);
    a = a ^ b ^ d; c = c ^ d ^ (b << 7);
    a = rl(a, 5); c = rl(c, 22);
    ms[i0] = a; ms[i1] = b; ms[i2] = c; ms[i3] = d;
  endtask

  task automatic m_round(int r);
    for (int i = 0; i < 32; i++) ms[i] ^= (mfin ? CF[i] : CN[i]);
    ms[1] ^= r;
    for (int i = 0; i < 8; i++) m_sbox(i, i + 8, i + 16, i + 24);
    for (int g = 0; g < 12; g++) m_mix(LG[g][0], LG[g][1], LG[g][2], LG[g][3]);
  endtask

  // predict the effect of the coming clock edge
  task automatic m_edge();
    if (rst) begin
      mbusy = 0; mdone = 0; mcnt = 0;
      for (int i = 0; i < 16; i++) mo[i] = 0;
    end else begin
      mdone = 0;
      if (!mbusy) begin
        if (start) begin
          for (int k = 0; k < 16; k++) begin
            ms[MPOS[k]] = msg_in[32*k +: 32];
            ms[CPOS[k]] = chain_in[32*k +: 32];
            mh[k] = chain_in[32*k +: 32];
          end
          mfin = final_mode; mlim = final_mode ? 12 : 6; mcnt = 0; mbusy = 1;
        end
      end else begin
        m_round(mcnt);
        mcnt++;
        if (mcnt == mlim) begin
          for (int i = 0; i < 16; i++) mo[i] = mh[i] ^ ms[(i < 8) ? i : i + 8];
          mbusy = 0; mdone = 1;
        end
      end
    end
  endtask

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic [511:0] eo;
    m_edge();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) eo[32*i +: 32] = mo[i];
    chk(busy === mbusy, "R2 busy", 512'(busy), 512'(mbusy));
    chk(done === mdone, "R4 done", 512'(done), 512'(mdone));
    chk(chain_out === eo, cur_req, chain_out, eo);
  endtask

  task automatic run_op(logic [511:0] m, logic [511:0] c, logic fin);
    msg_in = m; chain_in = c; final_mode = fin; start = 1'b1;
    cyc();
    start = 1'b0;
    while (mbusy) cyc();
    cyc();
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] walk;
    for (int i = 0; i < 16; i++) walk[32*i +: 32] = 32'h1 << (i * 2);
    @(negedge clk);
    repeat (3) cyc();
    chk(busy === 1'b0 && done === 1'b0, "R1 flags", {busy, done}, 512'd0);
    chk(chain_out === '0, "R1 out", chain_out, '0);
    rst = 1'b0;
    cyc();

    cur_req = "R3 R6 R7 R8 R9 R10 zero normal";
    run_op('0, '0, 1'b0);
    cur_req = "R6 R10 ones normal";
    run_op('1, '1, 1'b0);
    cur_req = "R6 R7 R8 R9 walking normal";
    run_op(walk, ~walk, 1'b0);
    cur_req = "R3 R7 zero final";
    run_op('0, '0, 1'b1);
    for (int n = 0; n < 4; n++) begin
      cur_req = "R3 R7 R10 random";
      run_op(rnd512(), rnd512(), n[0]);
    end

    // R5: start with other data while busy must not disturb the run
    cur_req = "R5 start ignored";
    msg_in = rnd512(); chain_in = rnd512(); final_mode = 1'b0; start = 1'b1;
    cyc();
    msg_in = rnd512(); chain_in = rnd512(); final_mode = 1'b1;
    repeat (3) cyc();
    start = 1'b0;
    while (mbusy) cyc();
    chk(done === 1'b1, "R5 done after 6", 512'(done), 512'd1);

    // R4: restart accepted in the cycle done is high
    cur_req = "R4 back to back";
    msg_in = rnd512(); chain_in = rnd512(); final_mode = 1'b1; start = 1'b1;
    cyc();
    start = 1'b0;
    chk(busy === 1'b1, "R4 restart", 512'(busy), 512'd1);
    while (mbusy) cyc();

    // R11: output holds through idle cycles with changing inputs
    cur_req = "R11 hold";
    for (int k = 0; k < 5; k++) begin
      msg_in = rnd512(); chain_in = rnd512();
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule